// File: doc/BRIEF.md
# Line and Frame Sync Regenerator

This block rebuilds horizontal and vertical sync for a video stream whose timing arrives only as markers embedded in the data. An upstream stage has already turned the start-of-active and end-of-active codes into a data-enable (DE) signal. This block watches that DE signal on the pixel clock and produces HSYNC and VSYNC pulses at programmed positions.

HSYNC is placed a programmed number of pixel clocks after each DE trailing edge and lasts a programmed number of pixel clocks. The block learns the line period from the spacing of DE trailing edges. Once DE stops arriving, it keeps emitting lines at that period, so that HSYNC continues through vertical blanking. Lines without a DE trailing edge are counted as blank lines. VSYNC starts and stops on HSYNC leading positions, and both its start and its width are counted in lines. Each output has its own polarity bit.

Top module: `sync_regen`

## Requirements
- R1: After reset, and until the first DE trailing edge (a cycle with `de` low that follows a cycle with `de` high), both outputs hold their inactive level.
- R2: If F is the first low-DE cycle of a trailing edge, HSYNC is active from cycle F+1+`hs_delay` for exactly `hs_width` cycles. This cycle F+1+`hs_delay` is the line's HSYNC leading position. When `hs_width` is 0, HSYNC never becomes active.
- R3: The line period is the number of cycles between the two most recent DE trailing edges. When a full period passes without a DE trailing edge, a new line starts anyway, and HSYNC is placed in it exactly as in R2.
- R4: Each line that starts without a DE trailing edge increments a blank-line index, which saturates. The first such line after DE activity is blank line 1, and a DE trailing edge sets the index to 0. VSYNC is inactive in every line outside the window given in R5 and R6.
- R5: VSYNC becomes active at the HSYNC leading position of blank line K, where K = `vs_delay`, or K = 1 when `vs_delay` is 0. That edge lands in the same cycle as the HSYNC leading edge whenever `hs_width` is nonzero.
- R6: VSYNC stays active for `vs_width` line periods and ends at the HSYNC leading position of blank line K+`vs_width`. When `vs_width` is 0, VSYNC never becomes active.
- R7: `hs_pol` and `vs_pol` each select the polarity of one output: 1 means active-high and 0 means active-low. The inactive level is the inverse of the active level.
- R8: A DE trailing edge that starts a new frame resets the blank-line count. A VSYNC that is still active at that point ends at the HSYNC leading position of that first active line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| de | input | 1 | Data enable recovered from the embedded markers |
| hs_delay | input | 10 | Pixel clocks from the DE trailing edge to the HSYNC leading edge |
| hs_width | input | 10 | HSYNC width in pixel clocks |
| vs_delay | input | 10 | Blank line on which VSYNC starts (0 is treated as 1) |
| vs_width | input | 10 | VSYNC width in line periods |
| hs_pol | input | 1 | HSYNC polarity, 1 = active-high |
| vs_pol | input | 1 | VSYNC polarity, 1 = active-high |
| hsync | output | 1 | Regenerated horizontal sync |
| vsync | output | 1 | Regenerated vertical sync |

## Verification
The hardest situation to reach is a VSYNC pulse that outlasts the vertical blanking interval. In that case the frame's first DE trailing edge has to cut the pulse short at its own HSYNC leading position. The stimulus reaches it by pairing `vs_delay` = 0 and a `vs_width` longer than the blank interval, and by placing VSYNC on the very last blank line. A per-cycle scoreboard tracks the line start, the learned period and the blank-line index from the DE pattern it drives. Whole frames, repeated back to back, also exercise the free-running lines in blanking and the saturation-free reset of the index.

// File: rtl/sync_regen_pkg.sv
// Shared types for the sync regenerator.
package sync_regen_pkg;
    // Kind of line boundary seen in a cycle.
    typedef enum logic [1:0] {
        BND_NONE = 2'd0,   // no new line this cycle
        BND_DE   = 2'd1,   // line started by a DE trailing edge
        BND_WRAP = 2'd2    // line started by the learned period running out
    } bnd_e;
endpackage

// File: rtl/sr_line_timer.sv
// Line timer: tracks the pixel position since the last line start.
// A line starts on a DE trailing edge or, once a period has been learned,
// when a full period passes without one. The period is the spacing of
// the two latest DE trailing edges.
// Assumes: the line period fits in CNT_W bits.
module sr_line_timer
    import sync_regen_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de,
    output logic [CNT_W-1:0] pos,
    output logic             seen,
    output bnd_e             bnd
);
    localparam logic [CNT_W-1:0] POS_MAX = '1;

    logic             de_q;
    logic [CNT_W-1:0] period;
    logic             fall;
    logic             wrap;

    assign fall = de_q & ~de;
    assign wrap = seen && (period != '0) && (pos == period - 1'b1);

    // Classify this cycle's boundary, with DE taking priority.
    always_comb begin
        if (fall)      bnd = BND_DE;
        else if (wrap) bnd = BND_WRAP;
        else           bnd = BND_NONE;
    end

    // Delay DE by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) de_q <= 1'b0;
        else        de_q <= de;
    end

    // Remember that at least one DE trailing edge has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n)    seen <= 1'b0;
        else if (fall) seen <= 1'b1;
    end

    // Learn the line period from consecutive DE trailing edges.
    always_ff @(posedge clk) begin
        if (!rst_n)            period <= '0;
        else if (fall && seen) period <= pos + 1'b1;
    end

    // Pixel position within the line, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                pos <= '0;
        else if (bnd != BND_NONE)  pos <= '0;
        else if (pos != POS_MAX)   pos <= pos + 1'b1;
    end
endmodule

// File: rtl/sr_frame_tracker.sv
// Frame tracker: counts blank lines and decides the VSYNC state.
// The VSYNC state switches at the HSYNC leading position. Before that
// position the previous line's decision is shown, and from it onward the
// current line's decision.
// Assumes: the line is longer than the HSYNC delay.
module sr_frame_tracker
    import sync_regen_pkg::*;
#(
    parameter int CFG_W = 10,
    parameter int IDX_W = CFG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bnd_e             bnd,
    input  logic             lead_reached,
    input  logic [CFG_W-1:0] vs_delay,
    input  logic [CFG_W-1:0] vs_width,
    output logic             vs_act
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] blank_idx;
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] stop_idx;
    logic             cur_on;
    logic             prev_on;

    // Window of blank lines that carry VSYNC.
    assign start_idx = (vs_delay == '0) ? IDX_W'(1) : IDX_W'(vs_delay);
    assign stop_idx  = start_idx + IDX_W'(vs_width);
    assign cur_on    = (blank_idx >= start_idx) && (blank_idx < stop_idx);
    assign vs_act    = lead_reached ? cur_on : prev_on;

    // Blank-line index: cleared by DE lines, advanced by free-running ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   blank_idx <= '0;
        else if (bnd == BND_DE)                       blank_idx <= '0;
        else if (bnd == BND_WRAP && blank_idx != IDX_MAX) blank_idx <= blank_idx + 1'b1;
    end

    // Keep the decision of the line that just ended.
    always_ff @(posedge clk) begin
        if (!rst_n)               prev_on <= 1'b0;
        else if (bnd != BND_NONE) prev_on <= cur_on;
    end
endmodule

// File: rtl/sr_pol_drive.sv
// Polarity stage: maps an active flag to a pin level for each channel.
// Assumes: a polarity bit of 1 means active-high.
module sr_pol_drive #(
    parameter int CH = 2
) (
    input  logic [CH-1:0] act,
    input  logic [CH-1:0] pol,
    output logic [CH-1:0] lvl
);
    genvar gi;
    generate
        for (gi = 0; gi < CH; gi++) begin : g_ch
            // Drive the active level when on and its inverse when off.
            assign lvl[gi] = ~(act[gi] ^ pol[gi]);
        end
    endgenerate
endmodule

// File: rtl/sync_regen.sv
// Sync regenerator top: rebuilds HSYNC and VSYNC from a recovered DE.
// HSYNC is placed relative to each line start, and VSYNC is placed by
// counting blank lines. Both outputs are decoded from registered state.
// Assumes: configuration is stable outside reset, and
// hs_delay + hs_width is less than the line period.
module sync_regen #(
    parameter int CFG_W = 10,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de,
    input  logic [CFG_W-1:0] hs_delay,
    input  logic [CFG_W-1:0] hs_width,
    input  logic [CFG_W-1:0] vs_delay,
    input  logic [CFG_W-1:0] vs_width,
    input  logic             hs_pol,
    input  logic             vs_pol,
    output logic             hsync,
    output logic             vsync
);
    import sync_regen_pkg::*;

    localparam int XW = CNT_W + 1;

    logic [CNT_W-1:0] pos;
    logic             seen;
    bnd_e             bnd;
    logic [XW-1:0]    pos_x;
    logic [XW-1:0]    lead_x;
    logic [XW-1:0]    end_x;
    logic             lead_reached;
    logic             hs_act;
    logic             vs_act;
    logic [1:0]       lvl;

    sr_line_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .de   (de),
        .pos  (pos),
        .seen (seen),
        .bnd  (bnd)
    );

    // HSYNC window relative to the line start.
    assign pos_x        = {1'b0, pos};
    assign lead_x       = XW'(hs_delay);
    assign end_x        = lead_x + XW'(hs_width);
    assign lead_reached = pos_x >= lead_x;
    assign hs_act       = seen && lead_reached && (pos_x < end_x);

    sr_frame_tracker #(.CFG_W(CFG_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .bnd         (bnd),
        .lead_reached(lead_reached),
        .vs_delay    (vs_delay),
        .vs_width    (vs_width),
        .vs_act      (vs_act)
    );

    sr_pol_drive #(.CH(2)) u_pol (
        .act({vs_act, hs_act}),
        .pol({vs_pol, hs_pol}),
        .lvl(lvl)
    );

    assign hsync = lvl[0];
    assign vsync = lvl[1];
endmodule

// File: rtl/sync_regen_chk.sv
// Checker for sync_regen: relates the output pins to DE and the settings.
// Assumes: configuration changes only while reset is held.
module sync_regen_chk #(
    parameter int CFG_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             de,
    input logic [CFG_W-1:0] hs_width,
    input logic [CFG_W-1:0] vs_width,
    input logic             hs_pol,
    input logic             vs_pol,
    input logic             hsync,
    input logic             vsync
);
    logic             hs_on;
    logic             vs_on;
    logic             de_d;
    logic             any_fall;
    logic [CFG_W:0]   run;

    assign hs_on = (hsync == hs_pol);
    assign vs_on = (vsync == vs_pol);

    // Track whether a DE trailing edge has occurred since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_d     <= 1'b0;
            any_fall <= 1'b0;
        end else begin
            de_d     <= de;
            any_fall <= any_fall | (de_d & ~de);
        end
    end

    // Length of the current HSYNC run.
    always_ff @(posedge clk) begin
        if (!rst_n)     run <= '0;
        else if (hs_on) run <= run + 1'b1;
        else            run <= '0;
    end

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_fall |-> (!hs_on && !vs_on));

    assert_hs_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_on) |-> (run == (CFG_W+1)'(hs_width)));

    assert_hs_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_width == '0) |-> !hs_on);

    assert_vs_on_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(vs_on) && hs_width != '0) |-> $rose(hs_on));

    assert_vs_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_width == '0) |-> !vs_on);
endmodule

bind sync_regen sync_regen_chk #(.CFG_W(CFG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .de      (de),
    .hs_width(hs_width),
    .vs_width(vs_width),
    .hs_pol  (hs_pol),
    .vs_pol  (vs_pol),
    .hsync   (hsync),
    .vsync   (vsync)
);

// File: tb/sync_regen_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver works out per-cycle expectations from the
// DE pattern it drives; the monitor compares them with the pins.
module sync_regen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       de = 1'b0;
    logic [9:0] hs_delay = '0;
    logic [9:0] hs_width = '0;
    logic [9:0] vs_delay = '0;
    logic [9:0] vs_width = '0;
    logic       hs_pol = 1'b1;
    logic       vs_pol = 1'b1;
    logic       hsync;
    logic       vsync;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Expected pin levels and requirement tags, one entry per cycle.
    bit exp_hs_q[$];
    bit exp_vs_q[$];
    int tag_hs_q[$];
    int tag_vs_q[$];

    // Reference state kept from the requirements.
    int n, ref_c, lm, bl;
    bit seen, pc, prev_de;

    always #2 clk = ~clk;

    sync_regen u_dut (
        .clk(clk), .rst_n(rst_n), .de(de),
        .hs_delay(hs_delay), .hs_width(hs_width),
        .vs_delay(vs_delay), .vs_width(vs_width),
        .hs_pol(hs_pol), .vs_pol(vs_pol),
        .hsync(hsync), .vsync(vsync)
    );

    function automatic string rq(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Blank-line window for VSYNC (R5, R6).
    function automatic bit vs_line(int idx);
        int k;
        k = (vs_delay == 0) ? 1 : int'(vs_delay);
        return (vs_width != 0) && (idx >= k) && (idx < k + int'(vs_width));
    endfunction

    // Push expectations for cycle n, drive DE for it, advance the reference.
    task automatic drive(bit dv);
        bit ha, va;
        int j, th, tv, k;
        ha = 0; va = 0;
        k = (vs_delay == 0) ? 1 : int'(vs_delay);
        if (seen) begin
            j  = n - ref_c - 1;
            ha = (j >= int'(hs_delay)) && (j < int'(hs_delay) + int'(hs_width));
            va = (j >= int'(hs_delay)) ? vs_line(bl) : pc;
        end
        if (!seen)        th = 1;
        else if (!hs_pol) th = 7;
        else if (bl > 0)  th = 3;
        else              th = 2;
        if (!seen)                              tv = 1;
        else if (bl == 0 && pc)                 tv = 8;
        else if (!vs_pol)                       tv = 7;
        else if (vs_width == 0)                 tv = 6;
        else if (bl == k)                       tv = 5;
        else if (bl > k && bl <= k + int'(vs_width)) tv = 6;
        else                                    tv = 4;
        exp_hs_q.push_back(hs_pol ? ha : !ha);
        exp_vs_q.push_back(vs_pol ? va : !va);
        tag_hs_q.push_back(th);
        tag_vs_q.push_back(tv);
        de = dv;
        if (prev_de && !dv) begin
            if (seen) lm = n - ref_c;
            pc = vs_line(bl);
            bl = 0;
            ref_c = n;
            seen = 1;
        end else if (seen && lm > 0 && n - ref_c == lm) begin
            pc = vs_line(bl);
            if (bl < 2047) bl++;
            ref_c = n;
        end
        prev_de = dv;
        n++;
        @(negedge clk);
    endtask

    // One scenario: settings, reset, idle lead-in, then whole frames.
    task automatic run_case(int d, int w, int vd, int vw, bit hp, bit vp,
                            int len, int ds, int dl, int act, int blank, int frames);
        @(negedge clk);
        rst_n = 1'b0;
        de = 1'b0;
        hs_delay = 10'(d); hs_width = 10'(w);
        vs_delay = 10'(vd); vs_width = 10'(vw);
        hs_pol = hp; vs_pol = vp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0; ref_c = 0; lm = 0; bl = 0; seen = 0; pc = 0; prev_de = 0;
        repeat (30) drive(1'b0);
        for (int f = 0; f < frames; f++)
            for (int ln = 0; ln < act + blank; ln++)
                for (int p = 0; p < len; p++)
                    drive((ln < act) && (p >= ds) && (p < ds + dl));
        repeat (len) drive(1'b0);
    endtask

    // Monitor: compare pins with the scoreboard away from the clock edge.
    always @(negedge clk) begin
        #0.5;
        if (exp_hs_q.size() > 0) begin
            bit eh, ev;
            int th, tv;
            eh = exp_hs_q.pop_front();
            ev = exp_vs_q.pop_front();
            th = tag_hs_q.pop_front();
            tv = tag_vs_q.pop_front();
            total += 2;
            if (hsync !== eh) begin
                bad++;
                $display("FAIL %s hsync at t=%0t: actual=%b expected=%b", rq(th), $time, hsync, eh);
            end
            if (vsync !== ev) begin
                bad++;
                $display("FAIL %s vsync at t=%0t: actual=%b expected=%b", rq(tv), $time, vsync, ev);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R2 R3 R4 R5 R6: basic placement, VSYNC on blank lines 3..4.
        run_case(5, 6, 3, 2, 1'b1, 1'b1, 40, 8, 20, 4, 8, 2);
        // R7 R8: active-low pins, vs_delay 0, VSYNC runs into the next frame.
        run_case(2, 3, 0, 9, 1'b0, 1'b0, 40, 8, 20, 4, 8, 2);
        // R2 R6: zero widths, mixed polarity.
        run_case(10, 0, 2, 0, 1'b1, 1'b0, 32, 4, 12, 3, 5, 2);
        // R5 R8: VSYNC on the last blank line, ended by the next frame.
        run_case(30, 15, 8, 1, 1'b1, 1'b1, 50, 6, 20, 3, 8, 2);
        // R1 R3: single active line per frame, long blanking.
        run_case(3, 4, 1, 3, 1'b1, 1'b1, 24, 2, 10, 1, 6, 3);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule